// File: doc/BRIEF.md
# Sprite DMA Fetch Sequencer

This block fetches sprite pattern bytes from memory once per scan line for four player sprites and one shared missile sprite, and loads each returned byte into one of five pattern registers. A three-bit mode input picks which channels run and whether a sprite byte spans one scan line or two. An 8-bit page number places the sprite memory area.

At each line-start pulse the block checks the line number against the active window and the mode. If a fetch is due, it latches the line, the page and the mode. It then walks the fetch slots in a fixed order, holding one read request on a simple request/valid memory port for each slot. Each returned byte goes to the pattern register for that slot, with a one-cycle write strobe. When players are enabled the missile slot is always fetched so that the line timing does not change. Its byte is only kept when missiles are enabled too.

Top module: `spr_dma_seq`

## Requirements
- R1: After reset, every pattern register reads zero, `mem_req_o` is low and `pat_we_o` is all zero.
- R2: Mode bits `dma_mode_i[1:0]` (bit 1 = players, bit 0 = missile) decode as follows. 00 gives no fetch at all. 01 gives one fetch, the missile slot only. 10 gives five fetches, and the missile byte is dropped, so pattern slot 0 keeps its value. 11 gives five fetches, and all five bytes are written.
- R3: Fetches within a line go in slot order: slot 0 (missile), then slots 1 to 4 (players 0 to 3). Each slot issues exactly one request. The request and its address stay unchanged until `mem_vld_i` is seen high at a clock edge.
- R4: A fetch sequence starts only for a line number from 8 to 247 inclusive. Line-start pulses outside that window cause no memory request.
- R5: Single-line mode (`dma_mode_i[2]`=1) uses this address: the page with bits [2:0] cleared, times 256, plus 0x300, plus slot×0x100, plus the low 8 bits of the line.
- R6: Double-line mode (`dma_mode_i[2]`=0) uses this address: the page with bits [1:0] cleared, times 256, plus 0x180, plus slot×0x80, plus the line divided by 2. Lines 2k and 2k+1 therefore read the same address, and a fetch still takes place on every line.
- R7: The page bits below the alignment for the current mode (bits [1:0] in double-line mode, bits [2:0] in single-line mode) have no effect on any address.
- R8: A byte accepted at a clock edge appears on its slot of `pat_o` after that edge. The matching bit of `pat_we_o` is high for exactly the following cycle, and at most one strobe bit is high at a time.
- R9: A line-start pulse that arrives while a sequence is running is ignored. Changes to the mode, page or line inputs during a sequence do not alter its addresses or writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dma_mode_i | input | 3 | [0] missile enable, [1] player enable, [2] single-line resolution |
| base_page_i | input | 8 | Sprite memory page number |
| line_start_i | input | 1 | One-cycle pulse at the start of a scan line |
| line_num_i | input | LINE_W | Current scan line number |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | 16 | Read address |
| mem_vld_i | input | 1 | Read data valid; completes the request at this edge |
| mem_rdata_i | input | 8 | Read data |
| pat_o | output | NUM_SLOT*8 | Pattern registers; slot 0 missile in bits [7:0], slot k player k-1 |
| pat_we_o | output | NUM_SLOT | Per-slot write strobe |

## Verification
The request rises in the cycle after the clock edge that samples the line-start pulse. Each slot then takes the memory latency plus one cycle. Each byte lands on `pat_o`, with its strobe, in the cycle after its handshake edge. The bench drives inputs at falling edges and uses a responder that raises valid after a chosen latency of 0 to 3 cycles. At those same falling edges it logs the requested addresses and the observed strobes. It compares all the logged values only after a wait of five times (latency+1) plus four cycles, so every slot has finished before the check. A strobe that lasted two cycles would be logged twice and would fail the count of writes.

// File: rtl/spr_dma_pkg.sv
package spr_dma_pkg;
  typedef enum logic {ST_IDLE, ST_FETCH} seq_state_e;

  typedef struct packed {
    logic single;
    logic plr_en;
    logic msl_en;
  } dma_mode_t;

  localparam int unsigned PAGE_W     = 8;
  localparam int unsigned ADDR_W     = 16;
  localparam logic [ADDR_W-1:0] DBL_REGION = 16'h0180;
  localparam logic [ADDR_W-1:0] SGL_REGION = 16'h0300;
  localparam int unsigned DBL_STRIDE_SH = 7;
  localparam int unsigned SGL_STRIDE_SH = 8;
endpackage

// File: rtl/spr_dma_addr.sv
module spr_dma_addr
  import spr_dma_pkg::*;
#(
  parameter int unsigned LINE_W = 9,
  parameter int unsigned SLOT_W = 3
) (
  input  logic [PAGE_W-1:0] base_page_i,
  input  logic              single_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [LINE_W-1:0] line_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] base_dbl, base_sgl, off_dbl, off_sgl;

  always_comb begin
    // 1 KB / 2 KB alignment: low page bits dropped
    base_dbl = {base_page_i[PAGE_W-1:2], 2'b00, 8'h00};
    base_sgl = {base_page_i[PAGE_W-1:3], 3'b000, 8'h00};
    off_dbl  = DBL_REGION + (ADDR_W'(slot_i) << DBL_STRIDE_SH)
             + ADDR_W'(line_i[LINE_W-1:1]);
    off_sgl  = SGL_REGION + (ADDR_W'(slot_i) << SGL_STRIDE_SH)
             + ADDR_W'(line_i[7:0]);
    addr_o   = single_i ? (base_sgl + off_sgl) : (base_dbl + off_dbl);
  end
endmodule

// File: rtl/spr_dma_ctl.sv
module spr_dma_ctl
  import spr_dma_pkg::*;
#(
  parameter int unsigned LINE_W     = 9,
  parameter int unsigned FIRST_LINE = 8,
  parameter int unsigned LAST_LINE  = 247,
  parameter int unsigned NUM_SLOT   = 5,
  localparam int unsigned SLOT_W    = $clog2(NUM_SLOT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  dma_mode_t         mode_i,
  input  logic [PAGE_W-1:0] base_page_i,
  input  logic              line_start_i,
  input  logic [LINE_W-1:0] line_num_i,
  input  logic              mem_vld_i,
  output logic              mem_req_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              single_o,
  output logic [PAGE_W-1:0] page_o,
  output logic [LINE_W-1:0] line_o,
  output logic              wr_en_o
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOT - 1);

  seq_state_e        state_q;
  logic [SLOT_W-1:0] slot_q, last_q;
  logic              msl_en_q, single_q;
  logic [PAGE_W-1:0] page_q;
  logic [LINE_W-1:0] line_q;
  logic              in_win, start, hs;

  always_comb begin
    in_win = (line_num_i >= LINE_W'(FIRST_LINE)) && (line_num_i <= LINE_W'(LAST_LINE));
    start  = line_start_i && (state_q == ST_IDLE) && in_win
             && (mode_i.msl_en || mode_i.plr_en);
    hs     = (state_q == ST_FETCH) && mem_vld_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      slot_q   <= '0;
      last_q   <= '0;
      msl_en_q <= 1'b0;
      single_q <= 1'b0;
      page_q   <= '0;
      line_q   <= '0;
    end else if (start) begin
      state_q  <= ST_FETCH;
      slot_q   <= '0;
      // players force the full slot walk, missile slot included
      last_q   <= mode_i.plr_en ? LAST_SLOT : '0;
      msl_en_q <= mode_i.msl_en;
      single_q <= mode_i.single;
      page_q   <= base_page_i;
      line_q   <= line_num_i;
    end else if (hs) begin
      if (slot_q == last_q) state_q <= ST_IDLE;
      else                  slot_q  <= slot_q + 1'b1;
    end
  end

  assign mem_req_o = (state_q == ST_FETCH);
  assign slot_o    = slot_q;
  assign single_o  = single_q;
  assign page_o    = page_q;
  assign line_o    = line_q;
  assign wr_en_o   = hs && ((slot_q != '0) || msl_en_q);
endmodule

// File: rtl/spr_dma_patbank.sv
module spr_dma_patbank #(
  parameter int unsigned NUM_SLOT = 5,
  parameter int unsigned DATA_W   = 8,
  localparam int unsigned SLOT_W  = $clog2(NUM_SLOT)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [SLOT_W-1:0]          wr_slot_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  output logic [NUM_SLOT*DATA_W-1:0] pat_o,
  output logic [NUM_SLOT-1:0]        pat_we_o
);
  for (genvar g = 0; g < NUM_SLOT; g++) begin : g_slot
    logic [DATA_W-1:0] q;
    logic              we_q;
    logic              sel;
    assign sel = wr_en_i && (wr_slot_i == SLOT_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q    <= '0;
        we_q <= 1'b0;
      end else begin
        we_q <= sel;
        if (sel) q <= wr_data_i;
      end
    end
    assign pat_o[g*DATA_W +: DATA_W] = q;
    assign pat_we_o[g]               = we_q;
  end
endmodule

// File: rtl/spr_dma_seq.sv
module spr_dma_seq
  import spr_dma_pkg::*;
#(
  parameter int unsigned LINE_W     = 9,
  parameter int unsigned FIRST_LINE = 8,
  parameter int unsigned LAST_LINE  = 247,
  parameter int unsigned NUM_PLR    = 4,
  parameter int unsigned DATA_W     = 8,
  localparam int unsigned NUM_SLOT  = NUM_PLR + 1,
  localparam int unsigned SLOT_W    = $clog2(NUM_SLOT)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [2:0]                 dma_mode_i,
  input  logic [7:0]                 base_page_i,
  input  logic                       line_start_i,
  input  logic [LINE_W-1:0]          line_num_i,
  output logic                       mem_req_o,
  output logic [15:0]                mem_addr_o,
  input  logic                       mem_vld_i,
  input  logic [DATA_W-1:0]          mem_rdata_i,
  output logic [NUM_SLOT*DATA_W-1:0] pat_o,
  output logic [NUM_SLOT-1:0]        pat_we_o
);
  dma_mode_t         mode;
  logic [SLOT_W-1:0] slot;
  logic              single, wr_en;
  logic [PAGE_W-1:0] page;
  logic [LINE_W-1:0] line;

  assign mode = dma_mode_t'(dma_mode_i);

  spr_dma_ctl #(
    .LINE_W(LINE_W), .FIRST_LINE(FIRST_LINE), .LAST_LINE(LAST_LINE), .NUM_SLOT(NUM_SLOT)
  ) u_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode), .base_page_i(base_page_i),
    .line_start_i(line_start_i), .line_num_i(line_num_i), .mem_vld_i(mem_vld_i),
    .mem_req_o(mem_req_o), .slot_o(slot), .single_o(single), .page_o(page),
    .line_o(line), .wr_en_o(wr_en)
  );

  spr_dma_addr #(.LINE_W(LINE_W), .SLOT_W(SLOT_W)) u_addr (
    .base_page_i(page), .single_i(single), .slot_i(slot), .line_i(line),
    .addr_o(mem_addr_o)
  );

  spr_dma_patbank #(.NUM_SLOT(NUM_SLOT), .DATA_W(DATA_W)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_slot_i(slot),
    .wr_data_i(mem_rdata_i), .pat_o(pat_o), .pat_we_o(pat_we_o)
  );
endmodule

// File: rtl/spr_dma_seq_chk.sv
module spr_dma_seq_chk #(
  parameter int unsigned LINE_W     = 9,
  parameter int unsigned FIRST_LINE = 8,
  parameter int unsigned LAST_LINE  = 247,
  parameter int unsigned NUM_SLOT   = 5
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [2:0]          dma_mode_i,
  input logic                line_start_i,
  input logic [LINE_W-1:0]   line_num_i,
  input logic                mem_req_o,
  input logic [15:0]         mem_addr_o,
  input logic                mem_vld_i,
  input logic [NUM_SLOT-1:0] pat_we_o
);
  p_req_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_vld_i) |=> (mem_req_o && $stable(mem_addr_o)));

  p_we_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pat_we_o));

  p_we_after_hs_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pat_we_o != '0) |-> $past(mem_req_o && mem_vld_i));

  p_off_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_start_i && !mem_req_o && (dma_mode_i[1:0] == 2'b00)) |=> !mem_req_o);

  p_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_start_i && !mem_req_o &&
     ((line_num_i < LINE_W'(FIRST_LINE)) || (line_num_i > LINE_W'(LAST_LINE))))
    |=> !mem_req_o);
endmodule

bind spr_dma_seq spr_dma_seq_chk #(
  .LINE_W(LINE_W), .FIRST_LINE(FIRST_LINE), .LAST_LINE(LAST_LINE), .NUM_SLOT(NUM_SLOT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .dma_mode_i(dma_mode_i), .line_start_i(line_start_i),
  .line_num_i(line_num_i), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
  .mem_vld_i(mem_vld_i), .pat_we_o(pat_we_o)
);

// File: tb/spr_dma_seq_tb_top.sv
module spr_dma_seq_tb_top;
  localparam int LINE_W = 9;
  localparam int NS     = 5;
  localparam int NV     = 14;

  // {mode[2:0], page[7:0], line[8:0], latency[1:0]}
  localparam logic [21:0] VEC [NV] = '{
    {3'b011, 8'h20, 9'd8,   2'd0},
    {3'b111, 8'h40, 9'd100, 2'd1},
    {3'b001, 8'h24, 9'd57,  2'd0},
    {3'b101, 8'h88, 9'd200, 2'd2},
    {3'b010, 8'h30, 9'd247, 2'd1},
    {3'b110, 8'h50, 9'd9,   2'd0},
    {3'b000, 8'h20, 9'd50,  2'd0},
    {3'b100, 8'h20, 9'd50,  2'd0},
    {3'b011, 8'h37, 9'd120, 2'd3},
    {3'b111, 8'h3F, 9'd7,   2'd0},
    {3'b111, 8'h10, 9'd248, 2'd0},
    {3'b111, 8'h17, 9'd33,  2'd2},
    {3'b011, 8'hC4, 9'd200, 2'd0},
    {3'b001, 8'hFF, 9'd246, 2'd1}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n;
  logic [2:0]        mode;
  logic [7:0]        page;
  logic              lstart;
  logic [LINE_W-1:0] lnum;
  logic              req, vld;
  logic [15:0]       addr;
  logic [7:0]        rdata;
  logic [NS*8-1:0]   pat;
  logic [NS-1:0]     we;

  spr_dma_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .dma_mode_i(mode), .base_page_i(page),
    .line_start_i(lstart), .line_num_i(lnum), .mem_req_o(req), .mem_addr_o(addr),
    .mem_vld_i(vld), .mem_rdata_i(rdata), .pat_o(pat), .pat_we_o(we)
  );

  int total = 0, bad = 0;
  int lat = 0;
  logic [15:0] alog [16];
  logic [2:0]  wslog [16];
  logic [7:0]  wdlog [16];
  int n_addr = 0, n_wr = 0;
  logic [7:0] exp_pat [NS];

  function automatic logic [7:0] mem_byte(logic [15:0] a);
    return a[7:0] ^ {a[12:8], 3'b101};
  endfunction

  function automatic logic [15:0] exp_addr(logic [2:0] m, logic [7:0] b, int ln, int s);
    if (m[2]) return 16'({b[7:3], 3'b000}) * 16'd256 + 16'h0300 + 16'(s * 256) + 16'(ln % 256);
    else      return 16'({b[7:2], 2'b00})  * 16'd256 + 16'h0180 + 16'(s * 128) + 16'(ln / 2);
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // memory responder and log
  initial begin
    vld = 1'b0;
    rdata = '0;
    forever begin
      int wcnt;
      @(negedge clk);
      for (int s = 0; s < NS; s++)
        if (we[s] && n_wr < 16) begin
          wslog[n_wr] = 3'(s);
          wdlog[n_wr] = pat[s*8 +: 8];
          n_wr++;
        end
      if (req && rst_n) begin
        if (wcnt >= lat) begin
          vld = 1'b1;
          rdata = mem_byte(addr);
          if (n_addr < 16) alog[n_addr] = addr;
          n_addr++;
          wcnt = 0;
        end else begin
          vld = 1'b0;
          wcnt++;
        end
      end else begin
        vld = 1'b0;
        wcnt = 0;
      end
    end
  end

  task automatic check_line(logic [2:0] m, logic [7:0] b, int ln);
    bit inwin = (ln >= 8) && (ln <= 247);
    int nf = !inwin ? 0 : (m[1] ? 5 : (m[0] ? 1 : 0));
    int w = 0;
    chk(n_addr == nf, "R2/R4 fetch count", 32'(n_addr), 32'(nf));
    for (int s = 0; s < nf && s < n_addr; s++)
      chk(alog[s] == exp_addr(m, b, ln, s), m[2] ? "R3/R5/R7 addr" : "R3/R6/R7 addr",
          32'(alog[s]), 32'(exp_addr(m, b, ln, s)));
    for (int s = 0; s < nf; s++) begin
      if (s == 0 && !m[0]) continue;
      exp_pat[s] = mem_byte(exp_addr(m, b, ln, s));
      if (w < n_wr) begin
        chk(wslog[w] == 3'(s), "R8 strobe slot", 32'(wslog[w]), 32'(s));
        chk(wdlog[w] == exp_pat[s], "R8 strobe data", 32'(wdlog[w]), 32'(exp_pat[s]));
      end
      w++;
    end
    chk(n_wr == w, "R8 write count", 32'(n_wr), 32'(w));
    for (int s = 0; s < NS; s++)
      chk(pat[s*8 +: 8] == exp_pat[s], "R2 pattern reg", 32'(pat[s*8 +: 8]), 32'(exp_pat[s]));
  endtask

  task automatic run_line(logic [2:0] m, logic [7:0] b, int ln, int l);
    n_addr = 0;
    n_wr = 0;
    lat = l;
    @(negedge clk);
    mode = m; page = b; lnum = LINE_W'(ln); lstart = 1'b1;
    @(negedge clk);
    lstart = 1'b0;
    repeat (5 * (l + 1) + 4) @(negedge clk);
    check_line(m, b, ln);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 32'(total), 32'(0));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] a10;
    rst_n = 1'b0; mode = '0; page = '0; lstart = 1'b0; lnum = '0;
    for (int s = 0; s < NS; s++) exp_pat[s] = '0;
    repeat (3) @(negedge clk);
    chk(req == 1'b0, "R1 req in reset", 32'(req), 32'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(req == 1'b0, "R1 req after reset", 32'(req), 32'(0));
    chk(pat == '0, "R1 patterns", 32'(pat[31:0]), 32'(0));
    chk(we == '0, "R1 strobes", 32'(we), 32'(0));

    for (int i = 0; i < NV; i++)
      run_line(VEC[i][21:19], VEC[i][18:11], int'(VEC[i][10:2]), int'(VEC[i][1:0]));

    // R6: even/odd line pair shares an address, next pair advances
    run_line(3'b011, 8'h10, 10, 0);
    a10 = alog[0];
    run_line(3'b011, 8'h10, 11, 1);
    chk(alog[0] == a10, "R6 pair same addr", 32'(alog[0]), 32'(a10));
    run_line(3'b011, 8'h10, 12, 0);
    chk(alog[0] == a10 + 16'd1, "R6 advance", 32'(alog[0]), 32'(a10 + 16'd1));

    // R9: second pulse and input changes during a running sequence
    n_addr = 0; n_wr = 0; lat = 3;
    @(negedge clk);
    mode = 3'b011; page = 8'h44; lnum = 9'd20; lstart = 1'b1;
    @(negedge clk);
    lstart = 1'b0;
    @(negedge clk);
    mode = 3'b101; page = 8'h90; lnum = 9'd31; lstart = 1'b1;
    @(negedge clk);
    lstart = 1'b0;
    repeat (26) @(negedge clk);
    check_line(3'b011, 8'h44, 20);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule